// File: doc/BRIEF.md
# GPIO Bank with Level and Edge Interrupts

This block is a bank of up to 32 general-purpose pins controlled through a small 32-bit register bus. The bus has a word address, separate read and write strobes, write data in and registered read data out. For each pin, software sets the driven value and the output enable, and reads back the pin level after it has passed through a synchronizer.

Each pin can also raise an interrupt in two ways. A level source is evaluated every cycle as the synchronized pin value XOR a polarity bit, gated by a level mask. An edge source detects a rising or falling edge, chosen per pin, and latches it in an event register that software clears by writing ones. The pending level and edge vectors are ORed into one summary bit. That bit passes through a single top-level enable to form the interrupt output.

The block has no sequential control flow, so it has no state machine. Its only timed behaviour is the synchronizer pipeline, the one-cycle read return and the event latch.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, every pin is an input (`pin_oe` zero, `pin_out` zero) and `irq` is low.
- R2: A read returns the addressed value on `bus_rdata` in the cycle after `bus_rd` is high. `bus_rdata` is zero in every cycle not preceded by a read, and it is zero for unmapped word addresses.
- R3: Word 17 (byte 0x44) holds the output data and word 18 (byte 0x48) holds the output enable. `pin_out` and `pin_oe` show these registers from the cycle after the write.
- R4: Word 16 (byte 0x40) is read-only and returns the pin inputs after a two-flop synchronizer. A change on `pin_in` becomes visible in the third cycle. Writes to this word have no effect.
- R5: Pending level sources equal (synchronized input XOR word 20) AND word 21. A polarity bit of 1 makes that pin active-low.
- R6: Word 25 (byte 0x64) selects the edge per pin: 0 detects rising and 1 detects falling. A detected edge sets that pin's bit in the event register, word 22 (byte 0x58).
- R7: Writing word 22 clears each event bit written as 1 and leaves bits written as 0 unchanged. An edge detected in the same cycle as its clear leaves the bit set.
- R8: Pending edge sources equal event AND word 23 (byte 0x5C).
- R9: Bit 0 of word 0 is 1 exactly when any level or edge source is pending. The word is read-only and its other bits read zero.
- R10: `irq` equals bit 0 of word 0 AND bit 0 of word 1. Word 1 stores only bit 0, and its other bits read zero.
- R11: Register bits at or above `NPINS` read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Value driven onto the pins |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets several timing and masking corners:
- Edges that arrive in the same cycle as their write-one-to-clear. A design that gives priority to the clear silently loses an event.
- Polarity flips on level sources. A design with inverted polarity sense raises `irq` while the pin is idle.
- The three-cycle input latency. A design that is one stage short or long shifts every data-in read and every edge by a cycle.
- Writes of all ones to every word with a narrow bank. This exposes stored high bits and writable read-only words.
- Reads of unmapped or idle cycles. A design that does not return zero there leaks stale data.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    // Word addresses (byte offset / 4); software depends on these positions.
    localparam logic [ADDR_W-1:0] W_TOP_STAT = 5'd0;
    localparam logic [ADDR_W-1:0] W_TOP_MASK = 5'd1;
    localparam logic [ADDR_W-1:0] W_DIN      = 5'd16;
    localparam logic [ADDR_W-1:0] W_DOUT     = 5'd17;
    localparam logic [ADDR_W-1:0] W_OE       = 5'd18;
    localparam logic [ADDR_W-1:0] W_LPOL     = 5'd20;
    localparam logic [ADDR_W-1:0] W_LMASK    = 5'd21;
    localparam logic [ADDR_W-1:0] W_EVENT    = 5'd22;
    localparam logic [ADDR_W-1:0] W_EMASK    = 5'd23;
    localparam logic [ADDR_W-1:0] W_EPOL     = 5'd25;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_in,
    input  logic [W-1:0] fall_sel,
    input  logic [W-1:0] clear_bits,
    output logic [W-1:0] event_q
);

    logic [W-1:0] last_q;
    logic [W-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else begin
            last_q <= level_in;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise;
        logic fall;
        assign rise   = level_in[i] & ~last_q[i];
        assign fall   = ~level_in[i] & last_q[i];
        assign hit[i] = fall_sel[i] ? fall : rise;
    end

    // A new edge wins over a clear that lands in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            event_q <= '0;
        end else begin
            event_q <= (event_q & ~clear_bits) | hit;
        end
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((event_q & $past(hit)) == $past(hit)));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clear_bits & ~hit)) |=> ((event_q & $past(clear_bits & ~hit)) == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clear_bits == '0) && (hit == '0)) |=> $stable(event_q));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    logic [NPINS-1:0] din_s;
    logic [NPINS-1:0] dout_q;
    logic [NPINS-1:0] oe_q;
    logic [NPINS-1:0] lpol_q;
    logic [NPINS-1:0] lmask_q;
    logic [NPINS-1:0] emask_q;
    logic [NPINS-1:0] epol_q;
    logic [NPINS-1:0] event_v;
    logic [NPINS-1:0] clr_v;
    logic [NPINS-1:0] wpins;
    logic [NPINS-1:0] lvl_pend;
    logic [NPINS-1:0] edg_pend;
    logic             tmask_q;
    logic             summary;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;

    assign wpins = bus_wdata[NPINS-1:0];

    gpio_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (din_s)
    );

    assign clr_v = (bus_wr && bus_addr == W_EVENT) ? wpins : '0;

    gpio_edge_unit #(.W(NPINS)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_in   (din_s),
        .fall_sel   (epol_q),
        .clear_bits (clr_v),
        .event_q    (event_v)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            oe_q    <= '0;
            lpol_q  <= '0;
            lmask_q <= '0;
            emask_q <= '0;
            epol_q  <= '0;
            tmask_q <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                W_TOP_MASK: tmask_q <= bus_wdata[0];
                W_DOUT:     dout_q  <= wpins;
                W_OE:       oe_q    <= wpins;
                W_LPOL:     lpol_q  <= wpins;
                W_LMASK:    lmask_q <= wpins;
                W_EMASK:    emask_q <= wpins;
                W_EPOL:     epol_q  <= wpins;
                default:    ;
            endcase
        end
    end

    assign lvl_pend = (din_s ^ lpol_q) & lmask_q;
    assign edg_pend = event_v & emask_q;
    assign summary  = |(lvl_pend | edg_pend);

    always_comb begin
        rd_val = '0;
        case (bus_addr)
            W_TOP_STAT: rd_val[0]         = summary;
            W_TOP_MASK: rd_val[0]         = tmask_q;
            W_DIN:      rd_val[NPINS-1:0] = din_s;
            W_DOUT:     rd_val[NPINS-1:0] = dout_q;
            W_OE:       rd_val[NPINS-1:0] = oe_q;
            W_LPOL:     rd_val[NPINS-1:0] = lpol_q;
            W_LMASK:    rd_val[NPINS-1:0] = lmask_q;
            W_EVENT:    rd_val[NPINS-1:0] = event_v;
            W_EMASK:    rd_val[NPINS-1:0] = emask_q;
            W_EPOL:     rd_val[NPINS-1:0] = epol_q;
            default:    rd_val            = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= bus_rd ? rd_val : '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = dout_q;
    assign pin_oe    = oe_q;
    assign irq       = summary & tmask_q;

    assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    assert_oe_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_OE) |=> (pin_oe == $past(wpins)));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tmask_q && (|(lvl_pend | edg_pend))));

    assert_mask_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == W_TOP_MASK) |=> (bus_rdata[DATA_W-1:1] == '0));

endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit cmp_en = 0;

    always #10 clk = ~clk;

    gpio_irq_bank #(.NPINS(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // Behavioural reference state
    logic [N-1:0] m_p1, m_p2, m_p3, m_dout, m_oe, m_lpol, m_lmask, m_ev, m_emask, m_epol;
    logic         m_tmask;
    logic [31:0]  m_rd;
    logic [4:0]   m_last_addr;

    function automatic logic m_stat();
        return |(((m_p2 ^ m_lpol) & m_lmask) | (m_ev & m_emask));
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            5'd0:  v[0] = m_stat();
            5'd1:  v[0] = m_tmask;
            5'd16: v[N-1:0] = m_p2;
            5'd17: v[N-1:0] = m_dout;
            5'd18: v[N-1:0] = m_oe;
            5'd20: v[N-1:0] = m_lpol;
            5'd21: v[N-1:0] = m_lmask;
            5'd22: v[N-1:0] = m_ev;
            5'd23: v[N-1:0] = m_emask;
            5'd25: v[N-1:0] = m_epol;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string req_of(input logic [4:0] a);
        case (a)
            5'd0:  return "R9";
            5'd1:  return "R10";
            5'd16: return "R4";
            5'd17, 5'd18: return "R3";
            5'd20, 5'd21: return "R5";
            5'd22: return "R7";
            5'd23: return "R8";
            5'd25: return "R6";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p1 = '0; m_p2 = '0; m_p3 = '0; m_dout = '0; m_oe = '0;
            m_lpol = '0; m_lmask = '0; m_ev = '0; m_emask = '0; m_epol = '0;
            m_tmask = 0; m_rd = '0; m_last_addr = '0;
        end else begin
            logic [N-1:0] hitv, clr;
            logic [31:0]  nrd;
            for (int i = 0; i < N; i++) begin
                if (m_epol[i]) hitv[i] = !m_p2[i] && m_p3[i];
                else           hitv[i] = m_p2[i] && !m_p3[i];
            end
            clr = (bus_wr && bus_addr == 5'd22) ? bus_wdata[N-1:0] : '0;
            nrd = bus_rd ? m_read(bus_addr) : '0;
            if (bus_rd) m_last_addr = bus_addr;
            m_ev = (m_ev & ~clr) | hitv;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin_in;
            m_rd = nrd;
            if (bus_wr) begin
                case (bus_addr)
                    5'd1:  m_tmask = bus_wdata[0];
                    5'd17: m_dout  = bus_wdata[N-1:0];
                    5'd18: m_oe    = bus_wdata[N-1:0];
                    5'd20: m_lpol  = bus_wdata[N-1:0];
                    5'd21: m_lmask = bus_wdata[N-1:0];
                    5'd23: m_emask = bus_wdata[N-1:0];
                    5'd25: m_epol  = bus_wdata[N-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            n_cmp += 4;
            if (bus_rdata !== m_rd) begin
                n_bad++;
                $display("FAIL R2 R11 %s rdata addr=%0d actual=%h expected=%h",
                         req_of(m_last_addr), m_last_addr, bus_rdata, m_rd);
            end
            if (pin_out !== m_dout) begin
                n_bad++;
                $display("FAIL R3 pin_out actual=%h expected=%h", pin_out, m_dout);
            end
            if (pin_oe !== m_oe) begin
                n_bad++;
                $display("FAIL R3 pin_oe actual=%h expected=%h", pin_oe, m_oe);
            end
            if (irq !== (m_stat() & m_tmask)) begin
                n_bad++;
                $display("FAIL R10 R5 R8 irq actual=%b expected=%b", irq, m_stat() & m_tmask);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic pins(input logic [N-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports
        n_cmp++;
        if (pin_oe !== '0 || pin_out !== '0 || irq !== 1'b0 || bus_rdata !== '0) begin
            n_bad++;
            $display("FAIL R1 reset outputs actual=%h/%h/%b/%h expected=0", pin_oe, pin_out, irq, bus_rdata);
        end
        cmp_en = 1;
        // R1: all registers read zero
        for (int a = 0; a < 32; a++) rd(a[4:0]);
        // R3, R11: output data and enable, high bits dropped
        wr(5'd18, 32'h00FF00FF);
        wr(5'd17, 32'hFFA5A5A5);
        rd(5'd17); rd(5'd18);
        wr(5'd17, 32'hFFFFFFFF);
        rd(5'd17);
        // R4: input sync latency, read-only data-in
        pins(24'h123456);
        rd(5'd16); rd(5'd16); rd(5'd16);
        wr(5'd16, 32'hFFFFFFFF);
        rd(5'd16);
        // R2: unmapped words and back-to-back reads
        rd(5'd2); rd(5'd31); rd(5'd19); rd(5'd24);
        // clear events created by the pin change
        wr(5'd22, 32'hFFFFFFFF);
        pins(24'h000000);
        idle(4);
        wr(5'd22, 32'hFFFFFFFF);
        // R5, R9, R10: level source with both polarities
        wr(5'd1, 32'hFFFFFFFF);
        rd(5'd1);
        wr(5'd21, 32'h1);
        idle(3);
        pins(24'h000001);
        idle(4);
        rd(5'd0);
        wr(5'd0, 32'h0);
        rd(5'd0);
        wr(5'd20, 32'h1);
        idle(2);
        rd(5'd0);
        pins(24'h000000);
        idle(4);
        rd(5'd0);
        wr(5'd21, 32'h0);
        wr(5'd20, 32'h0);
        wr(5'd22, 32'hFFFFFFFF);
        // R6, R8: falling edge on pin 1, rising on pin 2
        wr(5'd25, 32'h2);
        wr(5'd23, 32'h6);
        pins(24'h000002);
        idle(4);
        rd(5'd22);
        pins(24'h000000);
        idle(4);
        rd(5'd22); rd(5'd0);
        pins(24'h000004);
        idle(4);
        rd(5'd22);
        // R7: zero bits untouched, one bits cleared
        wr(5'd22, 32'h0);
        rd(5'd22);
        wr(5'd22, 32'h2);
        rd(5'd22);
        wr(5'd22, 32'h4);
        rd(5'd22);
        // R7: clear at every offset relative to an edge arrival
        for (int k = 0; k < 5; k++) begin
            pins(24'h000000);
            idle(4);
            wr(5'd22, 32'hFFFFFF);
            pins(24'h000004);
            idle(k);
            wr(5'd22, 32'h4);
            rd(5'd22);
        end
        // R10: top mask gates the output
        wr(5'd1, 32'h0);
        idle(2);
        rd(5'd0);
        wr(5'd1, 32'h1);
        // mixed traffic against the model
        for (int c = 0; c < 400; c++) begin
            logic [31:0] r;
            r = $urandom;
            case (r[2:0])
                3'd0, 3'd1: pins(N'($urandom));
                3'd2: wr(5'($urandom_range(0, 25)), $urandom);
                3'd3: wr(5'd22, $urandom);
                default: rd(5'($urandom));
            endcase
        end
        idle(4);
        finish_run();
    end

endmodule